// File: doc/BRIEF.md
# Microcoded GCD Engine

This block finds the greatest common divisor of two unsigned, nonzero operands using a fixed micro-program held in a small on-chip control store. A control-store address register selects one micro-instruction per cycle. The sequencing part of each word, made of a 3-bit jump kind and a target address, is combined with zero and carry flags from the datapath to pick the next address. The rest of the word drives an eight-entry register file, an accumulator, an ALU and a one-bit left shifter.

The program loads the first operand into register 0 and the second into the accumulator, one per accepted input beat. It then subtracts the smaller value from the larger one until the two are equal. The operand order is only a convention. Each loop pass uses three micro-instructions: an equality test, a shifted test whose carry is the sign of register 0 minus the accumulator, and a write-back of the difference. When the equality test sees a zero difference, the sequencer jumps to a terminal address that loops to itself. `done` is high while that address is selected, and `result` shows the accumulator. A reset is needed to start a new computation.

Top module: `ugcd`

## Requirements
- R1: While reset is applied (synchronous, active high) and in the cycle after it is released, `done` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only during the two input steps. An operand is taken on a rising edge where both `in_valid` and `in_ready` are 1. The first operand taken goes to register 0 and the second to the accumulator.
- R3: For nonzero operands a and b, `result` equals gcd(a, b) while `done` is 1.
- R4: Let k be the number of subtraction steps that repeated subtraction needs to make a and b equal. `done` rises exactly 3k+1 rising edges after the edge that takes the second operand.
- R5: Once `done` is 1, it stays 1 and `result` stays constant until reset. Input activity has no effect on either.
- R6: `in_ready` is 0 during the computation and while `done` is 1.
- R7: While an input step sees `in_valid` at 0, the sequencer stays on that step and `in_data` is ignored.
- R8: With equal operands, `done` rises one edge after the second operand is taken, and `result` equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W | Operand input |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Sequencer is at an input step |
| result | output | W | Accumulator contents (the GCD once done) |
| done | output | 1 | Sequencer is at the terminal address |

## Verification
The hardest things to reach from the ports are a long chain of subtractions that takes the carry branch at many different points, and a stall held on the second input step while the first operand sits in the register file. The bench builds the engine with 5-bit operands and runs every nonzero operand pair. This covers coprime pairs with the longest chains, equal pairs and both operand orders, and each result and latency is checked against a subtraction count made in the bench. Separate runs hold `in_valid` low with junk data on each input step. After completion, they drive extra input beats and confirm the finished result does not move.

// File: rtl/ugcd.sv
module ugcd #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int AW = 3;
  localparam int RW = $clog2(NREG);
  localparam int UW = 3 + AW + 2 + RW + 2 + 1;

  localparam logic [2:0] J_SEQ = 3'd0, J_GO = 3'd1, J_Z = 3'd2,
                         J_C = 3'd3, J_NZ = 3'd4, J_NC = 3'd5;
  localparam logic [1:0] D_NONE = 2'd0, D_ACC = 2'd1, D_REG = 2'd2;
  localparam logic [1:0] A_IN = 2'd0, A_RMA = 2'd1, A_AMR = 2'd2, A_REG = 2'd3;
  localparam logic [AW-1:0] L_CHK = 3'd2, L_SML = 3'd5, L_END = 3'd6;
  localparam logic [RW-1:0] R0 = '0;

  function automatic logic [UW-1:0] mi(input logic [2:0] nxt, input logic [AW-1:0] tgt,
                                       input logic [1:0] dst, input logic [RW-1:0] rs,
                                       input logic [1:0] op, input logic sh);
    return {nxt, tgt, dst, rs, op, sh};
  endfunction

  logic [AW-1:0] csar, csar_nx;
  logic [UW-1:0] uw;
  logic [2:0]    u_nxt;
  logic [AW-1:0] u_tgt;
  logic [1:0]    u_dst;
  logic [RW-1:0] u_rs;
  logic [1:0]    u_op;
  logic          u_sh;
  logic [W-1:0]  rf [NREG];
  logic [W-1:0]  acc;
  logic [W:0]    alu_y;
  logic [W-1:0]  sh_v;
  logic          f_c, f_z, stall, take;

  always_comb begin
    case (csar)
      3'd0:    uw = mi(J_SEQ, '0,    D_REG,  R0, A_IN,  1'b0);
      3'd1:    uw = mi(J_SEQ, '0,    D_ACC,  R0, A_IN,  1'b0);
      3'd2:    uw = mi(J_Z,   L_END, D_NONE, R0, A_RMA, 1'b0);
      3'd3:    uw = mi(J_C,   L_SML, D_NONE, R0, A_RMA, 1'b1);
      3'd4:    uw = mi(J_GO,  L_CHK, D_REG,  R0, A_RMA, 1'b0);
      3'd5:    uw = mi(J_GO,  L_CHK, D_ACC,  R0, A_AMR, 1'b0);
      default: uw = mi(J_GO,  L_END, D_NONE, R0, A_REG, 1'b0);
    endcase
  end

  assign {u_nxt, u_tgt, u_dst, u_rs, u_op, u_sh} = uw;

  always_comb begin
    case (u_op)
      A_IN:    alu_y = {1'b0, in_data};
      A_RMA:   alu_y = {1'b0, rf[u_rs]} - {1'b0, acc};
      A_AMR:   alu_y = {1'b0, acc} - {1'b0, rf[u_rs]};
      default: alu_y = {1'b0, rf[u_rs]};
    endcase
  end

  assign sh_v  = u_sh ? {alu_y[W-2:0], 1'b0} : alu_y[W-1:0];
  assign f_c   = u_sh & alu_y[W];
  assign f_z   = (sh_v == '0);
  assign stall = (u_op == A_IN) && !in_valid;

  always_comb begin
    case (u_nxt)
      J_GO:    take = 1'b1;
      J_Z:     take = f_z;
      J_C:     take = f_c;
      J_NZ:    take = !f_z;
      J_NC:    take = !f_c;
      default: take = 1'b0;
    endcase
    if (stall)     csar_nx = csar;
    else if (take) csar_nx = u_tgt;
    else           csar_nx = csar + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csar <= '0;
      acc  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      csar <= csar_nx;
      if (!stall && u_dst == D_ACC) acc <= sh_v;
      if (!stall && u_dst == D_REG) rf[u_rs] <= sh_v;
    end
  end

  assign in_ready = (u_op == A_IN);
  assign done     = (csar == L_END);
  assign result   = acc;
endmodule

module ugcd_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [W-1:0] result
);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && $stable(result));
  // R6
  no_ready_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready && !in_valid |=> in_ready && !done);
  // R4
  done_after_test_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !done);
  // R2
  ready_vs_done_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_ready, done}));
endmodule

bind ugcd ugcd_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .result(result)
);

// File: tb/tb_ugcd.sv
module tb_ugcd;
  localparam int W = 5;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, done;
  logic [W-1:0] result;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  ugcd #(.W(W)) dut (.clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
                     .in_ready(in_ready), .result(result), .done(done));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gcd_ref(input int a, input int b);
    while (b != 0) begin int t = a % b; a = b; b = t; end
    return a;
  endfunction

  function automatic int steps_ref(input int a, input int b);
    int k = 0;
    while (a != b) begin
      if (a > b) a = a - b; else b = b - a;
      k++;
    end
    return k;
  endfunction

  task automatic do_reset(input bit check);
    rst = 1; in_valid = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (check) begin
      chk(done == 0, "R1 done in reset", done, 0);
      chk(in_ready == 1, "R1 ready in reset", in_ready, 1);
    end
    rst = 0;
    @(posedge clk); @(negedge clk);
    if (check) begin
      chk(done == 0, "R1 done after reset", done, 0);
      chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
    end
  endtask

  task automatic run_pair(input int a, input int b, input int stall0, input int stall1,
                          input bit post);
    int n = 0;
    int k = steps_ref(a, b);
    int g = gcd_ref(a, b);
    do_reset(0);
    for (int s = 0; s < stall0; s++) begin
      in_valid = 0; in_data = W'(s + 7);
      @(posedge clk); @(negedge clk);
      chk(in_ready == 1 && done == 0, "R7 stall step0", in_ready, 1);
    end
    in_valid = 1; in_data = W'(a);
    @(posedge clk); @(negedge clk);
    chk(in_ready == 1, "R2 ready for second operand", in_ready, 1);
    for (int s = 0; s < stall1; s++) begin
      in_valid = 0; in_data = W'(s + 3);
      @(posedge clk); @(negedge clk);
      chk(in_ready == 1 && done == 0, "R7 stall step1", in_ready, 1);
    end
    in_valid = 1; in_data = W'(b);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(in_ready == 0, "R6 ready low while computing", in_ready, 0);
    while (!done && n < 400) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk(int'(result) == g, (a == b) ? "R8 equal result" : "R3 gcd result", result, g);
    chk(n == 3 * k + 1, (a == b) ? "R8 equal latency" : "R4 latency", n, 3 * k + 1);
    chk(in_ready == 0, "R6 ready low when done", in_ready, 0);
    if (post) begin
      for (int s = 0; s < 4; s++) begin
        in_valid = 1; in_data = W'(s * 5 + 1);
        @(posedge clk); @(negedge clk);
        chk(done == 1 && int'(result) == g, "R5 result held", result, g);
      end
      in_valid = 0;
    end
  endtask

  initial begin
    do_reset(1);
    for (int a = 1; a < (1 << W); a++)
      for (int b = 1; b < (1 << W); b++)
        run_pair(a, b, 0, 0, 0);
    run_pair(18, 12, 3, 0, 1);
    run_pair(7, 30, 0, 4, 1);
    run_pair(31, 1, 2, 2, 1);
    run_pair(9, 9, 1, 1, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule